// File: doc/BRIEF.md
# Pipeline Hazard Detection Unit

This block is the hazard-control logic for a five-stage integer pipeline (fetch, decode, execute, memory, writeback). Branches and jumps resolve in the decode stage. The unit is purely combinational. In each cycle it compares the source registers that the decode-stage instruction actually reads against the destinations of the instructions in the execute and memory stages. From that comparison it decides whether the front of the pipeline must stall or whether a taken control transfer must discard the fetched instruction.

A stall freezes the program counter and the fetch/decode register and turns the decode/execute register into a bubble. Operands produced by the ALU in execute reach a following ALU instruction through forwarding, so that case needs no stall. Two other cases cannot be covered by forwarding. A load result is not ready in time for its direct successor. A decode-stage branch or jump cannot use a value that is still in flight in execute, or a load that is still in memory. A taken branch or jump costs one cycle, because only the fetch/decode register is cleared.

Top module: `hazard_ctrl_unit`

## Requirements
- R1: When the execute-stage instruction is a load with write enable set, a nonzero destination, and a destination equal to a source the decode instruction reads, the unit stalls. This holds for any kind of decode instruction.
- R2: When the decode instruction is a branch or jump (`id_is_ctrl`=1) and reads a register that the execute-stage instruction writes (enabled, nonzero), the unit stalls, whether or not that producer is a load.
- R3: When a decode-stage branch or jump reads a register that a load in the memory stage writes (enabled, nonzero), the unit stalls.
- R4: A stall drives `pc_hold`=1, `ifid_hold`=1 and `idex_flush`=1 together, with `ifid_flush`=0.
- R5: When the decode stage reports a taken transfer (`id_taken`=1) and no stall is needed, only `ifid_flush` is 1 and the other three outputs are 0.
- R6: A non-branch decode instruction that depends on an execute-stage non-load result produces no stall.
- R7: A destination of register 0 never produces a hazard, in either stage.
- R8: A producer whose write enable is 0 never produces a hazard.
- R9: A source whose used flag is 0 is not compared. For example, a register-indirect jump marks only its first source as used.
- R10: A memory-stage load that matches a source of a non-branch decode instruction produces no stall.
- R11: A memory-stage non-load result that matches a source of a decode-stage branch produces no stall.
- R12: When a stall and `id_taken`=1 occur in the same cycle, the stall wins and `ifid_flush` is 0.
- R13: With all inputs at zero, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | 5 | First source register of the decode instruction |
| id_rs2 | input | 5 | Second source register of the decode instruction |
| id_rs1_used | input | 1 | Decode instruction reads its first source |
| id_rs2_used | input | 1 | Decode instruction reads its second source |
| id_is_ctrl | input | 1 | Decode instruction is a branch or jump |
| id_taken | input | 1 | Decode stage resolved a taken branch or jump |
| ex_rd | input | 5 | Destination register of the execute-stage instruction |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | 5 | Destination register of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| ifid_flush | output | 1 | Clear the fetch/decode register |
| idex_flush | output | 1 | Clear the decode/execute register (insert bubble) |

## Verification
The block holds no state, so a wrong comparison or priority shows at the outputs in the same cycle that the offending input pattern is applied. The three stall outputs must then disagree with the flush output, or stay at 0 when the pattern calls for a stall. A lost match bit shows up only when a dependent pair of instructions actually meets in the pipeline. For that reason the stimulus puts every producer class (load or ALU, execute or memory, enabled or not, register 0 or not) against every consumer class (branch or not, each source used or unused). A sweep over all 32 register indices also exposes a comparator that ignores address bits or mishandles register 0.

// File: rtl/hdu_pkg.sv
package hdu_pkg;

    localparam int REG_ADDR_W = 5;
    localparam int SRC_COUNT  = 2;

    // Pipeline front-end control produced for one cycle
    typedef struct packed {
        logic pc_hold;
        logic ifid_hold;
        logic ifid_flush;
        logic idex_flush;
    } pipe_ctl_t;

    localparam pipe_ctl_t CTL_IDLE = '{pc_hold: 1'b0, ifid_hold: 1'b0,
                                       ifid_flush: 1'b0, idex_flush: 1'b0};

    // A producer can create a dependency only if it writes a real register
    function automatic logic producer_live(input logic wen, input logic [REG_ADDR_W-1:0] rd);
        return wen && (rd != '0);
    endfunction

endpackage

// File: rtl/hdu_src_match.sv
module hdu_src_match #(
    parameter int ADDR_W  = hdu_pkg::REG_ADDR_W,
    parameter int NUM_SRC = hdu_pkg::SRC_COUNT
) (
    input  logic [NUM_SRC*ADDR_W-1:0] srcs,
    input  logic [NUM_SRC-1:0]        src_used,
    input  logic [ADDR_W-1:0]         dst,
    input  logic                      dst_wen,
    output logic [NUM_SRC-1:0]        hit
);
    logic live;

    always_comb begin
        live = dst_wen && (dst != '0);
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
        logic [ADDR_W-1:0] src_g;
        assign src_g  = srcs[g*ADDR_W +: ADDR_W];
        assign hit[g] = live && src_used[g] && (src_g == dst);

        always_comb begin
            // R9: an unread source never matches
            assert_unused_src_R9: assert (src_used[g] || !hit[g])
                else $error("unused source %0d reported a match", g);
            // a match means the addresses are equal
            assert_hit_equal_R1: assert (!hit[g] || (src_g == dst))
                else $error("match on differing addresses");
        end
    end

    always_comb begin
        // R7: register 0 never creates a dependency
        assert_zero_dst_R7: assert ((dst != '0) || (hit == '0))
            else $error("register 0 reported as a hazard");
        // R8: a non-writing producer never creates a dependency
        assert_no_wen_R8: assert (dst_wen || (hit == '0))
            else $error("non-writing producer reported as a hazard");
    end

endmodule

// File: rtl/hdu_stall_eval.sv
module hdu_stall_eval (
    input  logic ex_hit,
    input  logic ex_is_load,
    input  logic mem_hit,
    input  logic mem_is_load,
    input  logic id_is_ctrl,
    output logic stall
);
    logic load_use;
    logic ctrl_on_ex;
    logic ctrl_on_mem_load;

    always_comb begin
        load_use         = ex_hit && ex_is_load;
        ctrl_on_ex       = ex_hit && id_is_ctrl;
        ctrl_on_mem_load = mem_hit && mem_is_load && id_is_ctrl;
        stall            = load_use || ctrl_on_ex || ctrl_on_mem_load;
    end

    always_comb begin
        // R6: ALU result consumed by a non-branch is forwarded
        assert_alu_fwd_R6: assert (!(!id_is_ctrl && !ex_is_load && !mem_hit) || !stall)
            else $error("stall on forwardable ALU dependency");
        // R10: memory-stage load feeding a non-branch is forwarded
        assert_mem_fwd_R10: assert (!(!id_is_ctrl && !ex_hit) || !stall)
            else $error("stall on forwardable memory-stage value");
        // R11: memory-stage non-load never stalls a branch by itself
        assert_mem_alu_R11: assert (!(!mem_is_load && !ex_hit) || !stall)
            else $error("stall on memory-stage ALU value");
    end

endmodule

// File: rtl/hdu_ctl_gen.sv
module hdu_ctl_gen
    import hdu_pkg::*;
(
    input  logic      stall,
    input  logic      taken,
    output pipe_ctl_t ctl
);
    always_comb begin
        ctl = CTL_IDLE;
        if (stall) begin
            // freeze the front end, send a bubble into execute
            ctl.pc_hold    = 1'b1;
            ctl.ifid_hold  = 1'b1;
            ctl.idex_flush = 1'b1;
        end else if (taken) begin
            // drop only the wrong-path fetch
            ctl.ifid_flush = 1'b1;
        end
    end
endmodule

// File: rtl/hazard_ctrl_unit.sv
module hazard_ctrl_unit
    import hdu_pkg::*;
#(
    parameter int ADDR_W  = REG_ADDR_W,
    parameter int NUM_SRC = SRC_COUNT
) (
    input  logic [ADDR_W-1:0] id_rs1,
    input  logic [ADDR_W-1:0] id_rs2,
    input  logic              id_rs1_used,
    input  logic              id_rs2_used,
    input  logic              id_is_ctrl,
    input  logic              id_taken,
    input  logic [ADDR_W-1:0] ex_rd,
    input  logic              ex_wen,
    input  logic              ex_is_load,
    input  logic [ADDR_W-1:0] mem_rd,
    input  logic              mem_wen,
    input  logic              mem_is_load,
    output logic              pc_hold,
    output logic              ifid_hold,
    output logic              ifid_flush,
    output logic              idex_flush
);
    logic [NUM_SRC*ADDR_W-1:0] srcs;
    logic [NUM_SRC-1:0]        used;
    logic [NUM_SRC-1:0]        ex_hits;
    logic [NUM_SRC-1:0]        mem_hits;
    logic                      stall;
    pipe_ctl_t                 ctl;

    assign srcs = {id_rs2, id_rs1};
    assign used = {id_rs2_used, id_rs1_used};

    hdu_src_match #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)) u_ex_match (
        .srcs     (srcs),
        .src_used (used),
        .dst      (ex_rd),
        .dst_wen  (ex_wen),
        .hit      (ex_hits)
    );

    hdu_src_match #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)) u_mem_match (
        .srcs     (srcs),
        .src_used (used),
        .dst      (mem_rd),
        .dst_wen  (mem_wen),
        .hit      (mem_hits)
    );

    hdu_stall_eval u_stall (
        .ex_hit      (|ex_hits),
        .ex_is_load  (ex_is_load),
        .mem_hit     (|mem_hits),
        .mem_is_load (mem_is_load),
        .id_is_ctrl  (id_is_ctrl),
        .stall       (stall)
    );

    hdu_ctl_gen u_ctl (
        .stall (stall),
        .taken (id_taken),
        .ctl   (ctl)
    );

    assign pc_hold    = ctl.pc_hold;
    assign ifid_hold  = ctl.ifid_hold;
    assign ifid_flush = ctl.ifid_flush;
    assign idex_flush = ctl.idex_flush;

    always_comb begin
        // R4: a detected stall freezes PC and fetch/decode and inserts a bubble
        assert_stall_ctl_R4: assert (!stall || (pc_hold && ifid_hold && idex_flush))
            else $error("stall not reflected on hold/bubble outputs");
        // R12: stall outranks a taken transfer
        assert_stall_prio_R12: assert (!stall || !ifid_flush)
            else $error("flush issued during stall");
        // R5: taken without stall only clears fetch/decode
        assert_taken_flush_R5: assert (!(id_taken && !stall) || (ifid_flush && !pc_hold))
            else $error("taken transfer not flushed correctly");
        // R7: register-0 producers in both stages never stall
        assert_x0_quiet_R7: assert (!((ex_rd == '0) && (mem_rd == '0)) || !stall)
            else $error("stall caused by register 0");
    end

endmodule

// File: tb/test_hazard_ctrl_unit.sv
module test_hazard_ctrl_unit;

    logic clk = 1'b0;
    always #10 clk = ~clk; // 50 MHz

    logic [4:0] id_rs1, id_rs2, ex_rd, mem_rd;
    logic id_rs1_used, id_rs2_used, id_is_ctrl, id_taken;
    logic ex_wen, ex_is_load, mem_wen, mem_is_load;
    logic pc_hold, ifid_hold, ifid_flush, idex_flush;

    int checks = 0;
    int errors = 0;

    hazard_ctrl_unit i_hazard_ctrl_unit (
        .id_rs1(id_rs1), .id_rs2(id_rs2),
        .id_rs1_used(id_rs1_used), .id_rs2_used(id_rs2_used),
        .id_is_ctrl(id_is_ctrl), .id_taken(id_taken),
        .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
        .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_is_load(mem_is_load),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold),
        .ifid_flush(ifid_flush), .idex_flush(idex_flush)
    );

    // expected code: {pc_hold, ifid_hold, ifid_flush, idex_flush}
    localparam logic [3:0] E_STALL = 4'b1101;
    localparam logic [3:0] E_FLUSH = 4'b0010;
    localparam logic [3:0] E_NONE  = 4'b0000;

    // vector: rs1 rs2 u1 u2 ctrl exrd exwe exld memrd memwe memld taken exp
    function automatic logic [31:0] mk(
        input logic [4:0] rs1, input logic [4:0] rs2, input logic u1, input logic u2,
        input logic ctrl, input logic [4:0] exrd, input logic exwe, input logic exld,
        input logic [4:0] mrd, input logic mwe, input logic mld, input logic tk,
        input logic [3:0] exp);
        return {rs1, rs2, u1, u2, ctrl, exrd, exwe, exld, mrd, mwe, mld, tk, exp};
    endfunction

    localparam int NV = 13;
    localparam logic [31:0] VEC [NV] = '{
        mk(5'd3,  5'd4,  1, 1, 0, 5'd4,  1, 1, 5'd0,  0, 0, 0, E_STALL), // R1 load-use
        mk(5'd5,  5'd0,  1, 0, 1, 5'd5,  1, 0, 5'd0,  0, 0, 0, E_STALL), // R2 jump on EX ALU
        mk(5'd6,  5'd7,  1, 1, 1, 5'd0,  0, 0, 5'd7,  1, 1, 0, E_STALL), // R3 branch on MEM load
        mk(5'd1,  5'd2,  1, 1, 1, 5'd9,  1, 0, 5'd10, 1, 0, 1, E_FLUSH), // R5 taken, no dep
        mk(5'd1,  5'd2,  1, 1, 0, 5'd2,  1, 0, 5'd0,  0, 0, 0, E_NONE),  // R6 ALU forward
        mk(5'd0,  5'd0,  1, 1, 1, 5'd0,  1, 1, 5'd0,  1, 1, 0, E_NONE),  // R7 register 0
        mk(5'd8,  5'd9,  1, 1, 1, 5'd8,  0, 1, 5'd9,  0, 1, 0, E_NONE),  // R8 no write enable
        mk(5'd11, 5'd12, 1, 0, 1, 5'd12, 1, 1, 5'd12, 1, 1, 0, E_NONE),  // R9 rs2 unused
        mk(5'd13, 5'd14, 1, 1, 0, 5'd0,  0, 0, 5'd13, 1, 1, 0, E_NONE),  // R10 MEM load fwd
        mk(5'd15, 5'd16, 1, 1, 1, 5'd0,  0, 0, 5'd16, 1, 0, 1, E_FLUSH), // R11 MEM ALU, branch
        mk(5'd17, 5'd18, 1, 1, 1, 5'd17, 1, 0, 5'd0,  0, 0, 1, E_STALL), // R12 stall beats taken
        mk(5'd20, 5'd21, 0, 1, 0, 5'd21, 1, 1, 5'd0,  0, 0, 1, E_STALL), // R1 via rs2, R12
        mk(5'd3,  5'd4,  1, 1, 0, 5'd5,  1, 1, 5'd0,  0, 0, 0, E_NONE)   // R1 no address match
    };

    localparam string TAGS [NV] = '{"R1", "R2", "R3", "R5", "R6", "R7", "R8",
                                    "R9", "R10", "R11", "R12", "R12", "R1"};

    task automatic drive(input logic [31:0] v);
        {id_rs1, id_rs2, id_rs1_used, id_rs2_used, id_is_ctrl,
         ex_rd, ex_wen, ex_is_load, mem_rd, mem_wen, mem_is_load, id_taken} = v[31:4];
    endtask

    task automatic check(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {pc_hold, ifid_hold, ifid_flush, idex_flush};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: outputs=%b expected=%b", tag, act, exp);
        end
    endtask

    logic done = 1'b0;

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        // R13: idle inputs
        drive('0);
        @(negedge clk);
        check("R13", E_NONE);

        // table walk
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            check(TAGS[i], VEC[i][3:0]);
        end

        // R4: individual stall bits on a load-use case
        drive(VEC[0]);
        @(negedge clk);
        checks++;
        if (!(pc_hold === 1'b1 && ifid_hold === 1'b1 && idex_flush === 1'b1 && ifid_flush === 1'b0)) begin
            errors++;
            $display("FAIL R4: pc=%b ifid_hold=%b idex_flush=%b ifid_flush=%b expected 1 1 1 0",
                     pc_hold, ifid_hold, idex_flush, ifid_flush);
        end

        // R7/R1 sweep over every register index for a load-use pair
        for (int k = 0; k < 32; k++) begin
            drive(mk(k[4:0], 5'd0, 1, 0, 0, k[4:0], 1, 1, 5'd0, 0, 0, 0, E_NONE));
            @(negedge clk);
            check((k == 0) ? "R7" : "R1", (k == 0) ? E_NONE : E_STALL);
        end

        // R3/R7 sweep: branch on memory-stage load, each index
        for (int k = 0; k < 32; k++) begin
            drive(mk(5'd0, k[4:0], 0, 1, 1, 5'd0, 0, 0, k[4:0], 1, 1, 0, E_NONE));
            @(negedge clk);
            check((k == 0) ? "R7" : "R3", (k == 0) ? E_NONE : E_STALL);
        end

        // R2: off-by-one address must not match
        drive(mk(5'd6, 5'd0, 1, 0, 1, 5'd7, 1, 0, 5'd0, 0, 0, 1, E_FLUSH));
        @(negedge clk);
        check("R2", E_FLUSH);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule